// File: doc/BRIEF.md
# Retention-Aware Row Refresh Scheduler

This block sits inside a DRAM memory controller and decides, row by row, whether a refresh is needed now. Instead of refreshing every row at the worst-case interval, it keeps a small set of retention bins, each held as a Bloom filter. A row that matches a bin is refreshed at that bin's period. A row that matches no bin is refreshed at the slowest default period. After retention profiling, software or a boot sequencer loads the weak rows into the bins through the programming port. After that the scheduler only reads the bins.

A timebase pulse advances a row pointer through every row. One full sweep of the rows is one base slot of 64 ms. A slot counter counts base slots, modulo the longest period. Bin b, with b = 0 the shortest, holds rows whose retention lies between 2^b and 2^(b+1) base slots, so it is refreshed every 2^b slots. Unbinned rows are refreshed every 2^NUM_BINS slots. With the defaults there are two bins, for the 64–128 ms and 128–256 ms classes, and unbinned rows are refreshed every 256 ms. A row that is due raises a request that carries its address and is held until the command scheduler grants it.

Top module: `rtn_refresh_sched`

## Requirements
- R1: After reset, req_valid_o and overrun_o are 0, every filter is empty, and the row pointer and slot counter are 0.
- R2: Each tick_i cycle moves the row pointer up by one. After row 2^ROW_W-1 the pointer wraps to 0 and the slot counter moves up by one, modulo 2^NUM_BINS. Rows are therefore visited in ascending order.
- R3: Bloom-filter index j of a row r is ((r*(4j+3)) + (r >> FILT_W)) mod 2^FILT_W, for j = 0..NUM_HASH-1. A row is a member of a bin only if all NUM_HASH indexed bits of that bin are set.
- R4: A row that is a member of bin 0 (prog_bin_i = 0) is refreshed in every slot.
- R5: A row that is a member of bin 1, and not of bin 0, is refreshed only in slots whose index is even (slots 0 and 2).
- R6: A row that is a member of no bin is refreshed only in slot 0.
- R7: A row that is a member of several bins takes the period of the lowest-numbered bin it matches.
- R8: A cycle with clear_i high empties every filter. clear_i has priority over programming in the same cycle.
- R9: When the row under the pointer is due, the cycle after its tick shows req_valid_o = 1 and req_row_o = that row. Both hold steady until a cycle with req_grant_i high, and req_valid_o is 0 the cycle after that grant.
- R10: A tick_i while a request is pending and not being granted makes overrun_o 1 for exactly the next cycle. The pending request stays unchanged and the refresh of the newly visited row is dropped.
- R11: Programming a row only sets filter bits. Rows programmed earlier stay members.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse: visit the next row |
| clear_i | input | 1 | Empty all retention filters |
| prog_valid_i | input | 1 | Load prog_row_i into bin prog_bin_i |
| prog_bin_i | input | BIN_W | Target bin, 0 = shortest period |
| prog_row_i | input | ROW_W | Row address to program |
| req_valid_o | output | 1 | Refresh request pending |
| req_row_o | output | ROW_W | Row address of the pending refresh |
| req_grant_i | input | 1 | Command scheduler accepts the request |
| overrun_o | output | 1 | Pointer advanced while a request was pending |

## Verification
A request is due exactly one cycle after the clock edge that captures its tick. The monitor looks for it two nanoseconds after the following falling edge, with the grant held high, and compares the address against a queue that the driver fills from its own model of the row pointer, slot counter and Bloom filters before each tick. The grant clears the request on the next edge. Ticks are spaced three cycles apart, so each request is seen exactly once. For the stall case, the bench withholds the grant and checks at each falling edge: the overrun pulse one cycle after the second tick, the unchanged pending address during the stall, and the request going low one cycle after the grant.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int HASH_MUL_BASE = 3;
  localparam int HASH_MUL_STEP = 4;
endpackage

// File: rtl/rfs_bloom_bin.sv
module rfs_bloom_bin #(
  parameter int ROW_W    = 6,
  parameter int FILT_W   = 6,
  parameter int NUM_HASH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             prog_i,
  input  logic [ROW_W-1:0] prog_row_i,
  input  logic [ROW_W-1:0] look_row_i,
  output logic             hit_o
);
  import rfs_pkg::*;
  localparam int NBITS = 1 << FILT_W;
  localparam int PW    = ROW_W + FILT_W + 8;

  function automatic logic [FILT_W-1:0] hidx(input logic [ROW_W-1:0] r, input int j);
    logic [PW-1:0] p;
    p = PW'(r) * PW'(HASH_MUL_BASE + HASH_MUL_STEP * j);
    p = p + PW'(r >> FILT_W);
    return FILT_W'(p);
  endfunction

  logic [NBITS-1:0]    bits_q;
  logic [NBITS-1:0]    set_mask;
  logic [NUM_HASH-1:0] hit_vec;

  for (genvar j = 0; j < NUM_HASH; j++) begin : g_hash
    assign hit_vec[j] = bits_q[hidx(look_row_i, j)];
  end

  always_comb begin
    set_mask = '0;
    for (int j = 0; j < NUM_HASH; j++) set_mask[hidx(prog_row_i, j)] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bits_q <= '0;
    else if (clear_i) bits_q <= '0;
    else if (prog_i)  bits_q <= bits_q | set_mask;
  end

  assign hit_o = &hit_vec;

  assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (bits_q == '0));
  assert_bits_monotonic_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((bits_q & $past(bits_q)) == $past(bits_q)));
endmodule

// File: rtl/rfs_sweep.sv
module rfs_sweep #(
  parameter int ROW_W  = 6,
  parameter int SLOT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [ROW_W-1:0]  row_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      slot_q <= '0;
    end else if (tick_i) begin
      row_q <= row_q + 1'b1;
      if (row_q == {ROW_W{1'b1}}) slot_q <= slot_q + 1'b1;
    end
  end

  assign row_o  = row_q;
  assign slot_o = slot_q;

  assert_slot_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != $past(slot_q)) |-> ($past(row_q) == {ROW_W{1'b1}} && row_q == '0));
endmodule

// File: rtl/rtn_refresh_sched.sv
module rtn_refresh_sched #(
  parameter int ROW_W    = 6,
  parameter int FILT_W   = 6,
  parameter int NUM_HASH = 2,
  parameter int NUM_BINS = 2,
  localparam int BIN_W   = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1,
  localparam int SLOT_W  = NUM_BINS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic             prog_valid_i,
  input  logic [BIN_W-1:0] prog_bin_i,
  input  logic [ROW_W-1:0] prog_row_i,
  output logic             req_valid_o,
  output logic [ROW_W-1:0] req_row_o,
  input  logic             req_grant_i,
  output logic             overrun_o
);
  logic [ROW_W-1:0]    cur_row;
  logic [SLOT_W-1:0]   cur_slot;
  logic [NUM_BINS-1:0] hit;
  logic                due;
  logic                pending;
  logic                req_valid_q, overrun_q;
  logic [ROW_W-1:0]    req_row_q;

  rfs_sweep #(.ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_sweep (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .row_o (cur_row), .slot_o(cur_slot)
  );

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    rfs_bloom_bin #(.ROW_W(ROW_W), .FILT_W(FILT_W), .NUM_HASH(NUM_HASH)) u_bin (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (clear_i),
      .prog_i    (prog_valid_i && (prog_bin_i == BIN_W'(b))),
      .prog_row_i(prog_row_i),
      .look_row_i(cur_row),
      .hit_o     (hit[b])
    );
  end

  // descending scan: the lowest matching bin is written last and wins
  always_comb begin
    due = (cur_slot == '0);
    for (int b = NUM_BINS - 1; b >= 0; b--)
      if (hit[b]) due = ((cur_slot & SLOT_W'((1 << b) - 1)) == '0);
  end

  assign pending = req_valid_q && !req_grant_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_q <= 1'b0;
      req_row_q   <= '0;
      overrun_q   <= 1'b0;
    end else begin
      overrun_q <= tick_i && pending;
      if (req_valid_q && req_grant_i) req_valid_q <= 1'b0;
      if (tick_i && due && !pending) begin
        req_valid_q <= 1'b1;
        req_row_q   <= cur_row;
      end
    end
  end

  assign req_valid_o = req_valid_q;
  assign req_row_o   = req_row_q;
  assign overrun_o   = overrun_q;

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_grant_i) |=> (req_valid_o && $stable(req_row_o)));
  assert_req_after_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(tick_i));
  assert_overrun_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(tick_i && req_valid_o && !req_grant_i));
endmodule

// File: tb/sim_rtn_refresh_sched.sv
module sim_rtn_refresh_sched;
  localparam int RW = 6, FW = 6, NH = 2, NB = 2;
  localparam int NROWS = 1 << RW;

  logic clk = 0, rst_n = 0;
  logic tick = 0, clr = 0, pv = 0, grant = 1;
  logic [0:0] pbin = '0;
  logic [RW-1:0] prow = '0;
  logic req_v, ovr;
  logic [RW-1:0] req_r;

  int errors = 0, checks = 0;
  int exp_q[$];
  string tag_q[$];
  bit [NROWS-1:0] mf [NB];
  int brow = 0, bslot = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtn_refresh_sched #(.ROW_W(RW), .FILT_W(FW), .NUM_HASH(NH), .NUM_BINS(NB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .clear_i(clr),
    .prog_valid_i(pv), .prog_bin_i(pbin), .prog_row_i(prow),
    .req_valid_o(req_v), .req_row_o(req_r), .req_grant_i(grant), .overrun_o(ovr));

  function automatic int bidx(int r, int j);
    return ((r * (4 * j + 3)) + (r >> FW)) % (1 << FW);
  endfunction

  function automatic bit member(int b, int r);
    for (int j = 0; j < NH; j++) if (!mf[b][bidx(r, j)]) return 0;
    return 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic program_row(int b, int r);
    @(negedge clk); pv = 1; pbin = 1'(b); prow = RW'(r);
    @(negedge clk); pv = 0;
    for (int j = 0; j < NH; j++) mf[b][bidx(r, j)] = 1;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
  endtask

  // model of one visit; pushes expectation before the tick
  task automatic step_visit();
    bit due; string t;
    if (member(0, brow)) begin due = 1; t = "R4/R7"; end
    else if (member(1, brow)) begin due = (bslot % 2 == 0); t = "R5"; end
    else begin due = (bslot == 0); t = "R6"; end
    if (due) begin exp_q.push_back(brow); tag_q.push_back({t, " R2 R3 R11"}); end
    do_tick();
    brow = (brow + 1) % NROWS;
    if (brow == 0) bslot = (bslot + 1) % (1 << NB);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && req_v && grant) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected refresh", int'(req_r), -1);
        else begin
          int e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(int'(req_r) == e, t, int'(req_r), e);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mf[0] = '0; mf[1] = '0;
    repeat (3) @(negedge clk);
    chk(req_v == 0, "R1 req_valid", int'(req_v), 0);
    chk(ovr == 0, "R1 overrun", int'(ovr), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_v == 0, "R1 req_valid after release", int'(req_v), 0);
    program_row(0, 5);
    program_row(1, 5);   // R7: both bins, shortest wins
    program_row(1, 9);
    program_row(1, 20);
    program_row(0, 40);  // R11: row 5 must still be in bin 0
    for (int i = 0; i < 4 * NROWS; i++) step_visit();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 R5 R6 all expected refreshes seen", exp_q.size(), 0);
    // R8: clear
    @(negedge clk); clr = 1; pv = 1; pbin = 0; prow = 7;
    @(negedge clk); clr = 0; pv = 0;
    mf[0] = '0; mf[1] = '0;
    for (int i = 0; i < 4 * NROWS; i++) step_visit();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 after clear only slot-0 refreshes", exp_q.size(), 0);
    // R9 / R10 stall
    chk(brow == 0 && bslot == 0, "R2 model at slot 0 row 0", brow, 0);
    @(negedge clk); grant = 0; tick = 1;
    @(negedge clk); tick = 0;
    chk(req_v == 1, "R9 request one cycle after tick", int'(req_v), 1);
    chk(req_r == 0, "R9 request row", int'(req_r), 0);
    tick = 1;
    @(negedge clk); tick = 0;
    chk(ovr == 1, "R10 overrun pulse", int'(ovr), 1);
    chk(req_v == 1 && req_r == 0, "R10 pending request unchanged", int'(req_r), 0);
    @(negedge clk);
    chk(ovr == 0, "R10 overrun one cycle only", int'(ovr), 0);
    chk(req_v == 1 && req_r == 0, "R9 held while not granted", int'(req_r), 0);
    exp_q.push_back(0); tag_q.push_back("R9 granted row");
    grant = 1;
    @(negedge clk);
    chk(req_v == 0, "R9 low after grant", int'(req_v), 0);
    repeat (4) @(negedge clk);
    chk(req_v == 0 && exp_q.size() == 0, "R10 dropped row not requested", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule